// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block produces the byte a flash device returns on its data pins while an internal program or erase is under way. A read is signalled by a strobe; each new read advances two independent toggle bits. Bit 6 is a device-wide activity toggle: it flips on every read while an operation runs. Bit 2 is sector-selective: it flips only when the read address falls in a sector that is really being erased. Bit 5 reports that the internal pulse-count limit was exceeded. When no operation is active, the block passes the array data through.

The internal program and erase engines are outside the block and appear as level mode inputs. A program or erase aimed only at protected sectors is handled inside the block. It opens a fixed toggle window, counted in clock cycles. During that window bit 6 toggles, and after it the block returns to array data. The output byte is registered; a read's status is visible on the cycle after the strobe's rising edge is sampled.

Top module: `flash_status_gen`

## Requirements
- R1: While `rst_n` is low, `dq_out` is 8'h00 and both toggle states are cleared to 0.
- R2: While a program runs (`op_program`) or an erase runs unsuspended (`op_erase` high, `op_suspend` low), every read rising edge inverts bit 6 relative to the previous read. Once these inputs drop, reads return `array_data`.
- R3: With no operation active, `dq_out` equals the `array_data` value sampled on the previous clock edge.
- R4: In erase suspend (`op_suspend` high, `op_susp_prog` low), bit 6 holds its value across reads. Reads of a sector not being erased return `array_data`.
- R5: While `op_susp_prog` is high, bit 6 inverts on every read. After it falls, bit 6 holds again.
- R6: During an erase or erase suspend, bit 2 inverts on each read whose `rd_sector` is set in `erase_sel` and clear in `prot_mask`.
- R7: A `go_prog` pulse whose `prog_sector` is set in `prot_mask` opens a window of `PROT_WIN` cycles. During the window bit 6 inverts on each read. After the window, reads return `array_data`.
- R8: A `go_erase` pulse with a non-zero `erase_sel` whose set sectors are all protected opens the same window. Protected sectors in `erase_sel` never advance bit 2.
- R9: In every status byte, bit 5 equals `op_timeout`.
- R10: In every status byte, bits 7, 4, 3, 1 and 0 are 0.
- R11: Toggle states change only on a low-to-high transition of `rd_strobe`. Holding the strobe high does not advance them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_strobe | input | 1 | Read strobe; a rising edge is one read |
| rd_sector | input | SEC_W | Sector index of the read address |
| go_prog | input | 1 | One-cycle pulse: program command accepted |
| prog_sector | input | SEC_W | Sector targeted by that program |
| go_erase | input | 1 | One-cycle pulse: erase command accepted |
| erase_sel | input | NUM_SECTORS | Sectors selected for erase |
| prot_mask | input | NUM_SECTORS | Protected sectors |
| op_program | input | 1 | Internal program running |
| op_erase | input | 1 | Erase operation in progress |
| op_suspend | input | 1 | Erase is suspended |
| op_susp_prog | input | 1 | Program running inside erase suspend |
| op_timeout | input | 1 | Pulse-count limit exceeded |
| array_data | input | 8 | Array read data |
| dq_out | output | 8 | Returned data byte |

## Verification
The bench builds the block with eight sectors and `PROT_WIN` set to 20 cycles. At that window length, both the inside and the end of a protected-program window and of a protected-erase window are covered in a few dozen cycles. With eight sectors, the selected, protected, and unselected cases can all sit in one erase mask. This lets bit 2 advance on one sector and hold on the other two within the same erase.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
    localparam int BIT_Q6 = 6;
    localparam int BIT_Q5 = 5;
    localparam int BIT_Q2 = 2;

    typedef struct packed {
        logic       rd;
        logic       t6;
        logic       t2;
        logic [7:0] dq;
    } core_state_t;
endpackage

// File: rtl/fsg_sector_decode.sv
module fsg_sector_decode #(
    parameter int NUM_SECTORS = 8,
    localparam int SEC_W = $clog2(NUM_SECTORS)
) (
    input  logic [NUM_SECTORS-1:0] erase_sel,
    input  logic [NUM_SECTORS-1:0] prot_mask,
    input  logic [SEC_W-1:0]       rd_sector,
    input  logic [SEC_W-1:0]       prog_sector,
    input  logic                   go_prog,
    input  logic                   go_erase,
    output logic                   sel_hit,
    output logic                   abort_start
);
    logic [NUM_SECTORS-1:0] live_sel;

    for (genvar i = 0; i < NUM_SECTORS; i++) begin : g_live
        assign live_sel[i] = erase_sel[i] & ~prot_mask[i];
    end

    always_comb begin
        sel_hit     = live_sel[rd_sector];
        abort_start = (go_prog & prot_mask[prog_sector])
                    | (go_erase & (|erase_sel) & ~(|live_sel));
    end
endmodule

// File: rtl/fsg_abort_timer.sv
module fsg_abort_timer #(
    parameter int PROT_WIN = 200,
    localparam int CNT_W = $clog2(PROT_WIN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             active,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)
            cnt_d = CNT_W'(PROT_WIN);
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign active = (cnt_q != '0);
    assign count  = cnt_q;
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen #(
    parameter int NUM_SECTORS = 8,
    parameter int PROT_WIN    = 200,
    localparam int SEC_W = $clog2(NUM_SECTORS),
    localparam int CNT_W = $clog2(PROT_WIN + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rd_strobe,
    input  logic [SEC_W-1:0]       rd_sector,
    input  logic                   go_prog,
    input  logic [SEC_W-1:0]       prog_sector,
    input  logic                   go_erase,
    input  logic [NUM_SECTORS-1:0] erase_sel,
    input  logic [NUM_SECTORS-1:0] prot_mask,
    input  logic                   op_program,
    input  logic                   op_erase,
    input  logic                   op_suspend,
    input  logic                   op_susp_prog,
    input  logic                   op_timeout,
    input  logic [7:0]             array_data,
    output logic [7:0]             dq_out
);
    import fsg_pkg::*;

    core_state_t      st_d, st_q;
    logic             sel_hit, abort_start, abort_active;
    logic [CNT_W-1:0] abort_cnt;
    logic             rise, run_now, show_status;
    logic             rd_q, t6_q, t2_q;
    logic [7:0]       stat_byte;

    fsg_sector_decode #(.NUM_SECTORS(NUM_SECTORS)) u_dec (
        .erase_sel   (erase_sel),
        .prot_mask   (prot_mask),
        .rd_sector   (rd_sector),
        .prog_sector (prog_sector),
        .go_prog     (go_prog),
        .go_erase    (go_erase),
        .sel_hit     (sel_hit),
        .abort_start (abort_start)
    );

    fsg_abort_timer #(.PROT_WIN(PROT_WIN)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (abort_start),
        .active (abort_active),
        .count  (abort_cnt)
    );

    always_comb begin
        rise        = rd_strobe & ~st_q.rd;
        run_now     = op_program | (op_erase & ~op_suspend) | op_susp_prog | abort_active;
        show_status = run_now | (op_suspend & sel_hit);

        st_d    = st_q;
        st_d.rd = rd_strobe;
        if (rise && run_now)
            st_d.t6 = ~st_q.t6;
        if (rise && (op_erase || op_suspend) && sel_hit)
            st_d.t2 = ~st_q.t2;

        stat_byte         = '0;
        stat_byte[BIT_Q6] = st_d.t6;
        stat_byte[BIT_Q5] = op_timeout;
        stat_byte[BIT_Q2] = st_d.t2;
        st_d.dq = show_status ? stat_byte : array_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dq_out = st_q.dq;
    assign rd_q   = st_q.rd;
    assign t6_q   = st_q.t6;
    assign t2_q   = st_q.t2;
endmodule

// File: rtl/fsg_checker.sv
module fsg_checker #(
    parameter int PROT_WIN = 200,
    localparam int CNT_W = $clog2(PROT_WIN + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_strobe,
    input logic             rd_q,
    input logic             run_now,
    input logic             op_timeout,
    input logic             t6_q,
    input logic             t2_q,
    input logic             abort_start,
    input logic [CNT_W-1:0] abort_cnt,
    input logic [7:0]       dq_out
);
    a_r2_q6_inverts: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !rd_q && run_now) |=> (t6_q != $past(t6_q)));

    a_r11_hold_without_edge: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_strobe && !rd_q) |=> ($stable(t6_q) && $stable(t2_q)));

    a_r10_spare_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        run_now |=> ((dq_out & 8'h9B) == 8'h00));

    a_r9_timeout_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (run_now && op_timeout) |=> dq_out[5]);

    a_r7_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
        abort_cnt <= CNT_W'(PROT_WIN));

    a_r7_window_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_cnt != '0 && !abort_start) |=> (abort_cnt == CNT_W'($past(abort_cnt) - 1'b1)));
endmodule

bind flash_status_gen fsg_checker #(.PROT_WIN(PROT_WIN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_strobe   (rd_strobe),
    .rd_q        (rd_q),
    .run_now     (run_now),
    .op_timeout  (op_timeout),
    .t6_q        (t6_q),
    .t2_q        (t2_q),
    .abort_start (abort_start),
    .abort_cnt   (abort_cnt),
    .dq_out      (dq_out)
);

// File: tb/flash_status_gen_test.sv
module flash_status_gen_test;
    localparam int NS  = 8;
    localparam int WIN = 20;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          rd_strobe = 0;
    logic [2:0]    rd_sector = 0;
    logic          go_prog = 0;
    logic [2:0]    prog_sector = 0;
    logic          go_erase = 0;
    logic [NS-1:0] erase_sel = 0;
    logic [NS-1:0] prot_mask = 0;
    logic          op_program = 0, op_erase = 0, op_suspend = 0, op_susp_prog = 0, op_timeout = 0;
    logic [7:0]    array_data = 8'hA5;
    logic [7:0]    dq_out;

    int    n_run = 0, n_fail = 0;
    string phase = "R1";

    flash_status_gen #(.NUM_SECTORS(NS), .PROT_WIN(WIN)) uut (
        .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .rd_sector(rd_sector),
        .go_prog(go_prog), .prog_sector(prog_sector), .go_erase(go_erase),
        .erase_sel(erase_sel), .prot_mask(prot_mask), .op_program(op_program),
        .op_erase(op_erase), .op_suspend(op_suspend), .op_susp_prog(op_susp_prog),
        .op_timeout(op_timeout), .array_data(array_data), .dq_out(dq_out)
    );

    always #5 clk = ~clk;

    // behavioural reference
    bit   m_rd, m_t6, m_t2, m_rise, m_run, m_stat, m_hit, m_trig, m_armed;
    int   m_cnt;
    logic [7:0] m_dq;

    always @(posedge clk) begin
        m_armed = 1;
        if (!rst_n) begin
            m_rd = 0; m_t6 = 0; m_t2 = 0; m_cnt = 0; m_dq = 8'h00;
        end else begin
            m_rise = rd_strobe && !m_rd;
            m_hit  = erase_sel[rd_sector] && !prot_mask[rd_sector];
            m_run  = op_program || (op_erase && !op_suspend) || op_susp_prog || (m_cnt > 0);
            m_stat = m_run || (op_suspend && m_hit);
            if (m_rise && m_run) m_t6 = !m_t6;
            if (m_rise && (op_erase || op_suspend) && m_hit) m_t2 = !m_t2;
            m_dq = m_stat ? {1'b0, m_t6, op_timeout, 2'b00, m_t2, 2'b00} : array_data;
            m_trig = (go_prog && prot_mask[prog_sector]) ||
                     (go_erase && erase_sel != 0 && (erase_sel & ~prot_mask) == 0);
            if (m_trig) m_cnt = WIN;
            else if (m_cnt > 0) m_cnt = m_cnt - 1;
            m_rd = rd_strobe;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    always @(negedge clk)
        if (m_armed) chk(dq_out === m_dq, {phase, " model"}, dq_out, m_dq);

    task automatic rd(input int sec, output logic [7:0] v);
        @(negedge clk);
        rd_sector = 3'(sec);
        rd_strobe = 1;
        @(negedge clk);
        v = dq_out;
        rd_strobe = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] a, b, c;
        idle(3);
        chk(dq_out === 8'h00, "R1 reset", dq_out, 0);
        rst_n = 1;

        phase = "R3";
        rd(0, a);
        chk(a == 8'hA5, "R3 idle read", a, 8'hA5);
        array_data = 8'h3C; idle(2);
        chk(dq_out == 8'h3C, "R3 passthrough", dq_out, 8'h3C);

        phase = "R2"; op_program = 1;
        rd(3, a); rd(6, b); rd(1, c);
        chk(a[6] != b[6], "R2 q6 flip 1", b[6], !a[6]);
        chk(b[6] != c[6], "R2 q6 flip 2", c[6], !b[6]);
        chk((a & 8'h9B) == 0, "R10 spare bits", a, a & 8'h64);
        chk(a[5] == 0, "R9 q5 low", a[5], 0);
        op_timeout = 1; rd(2, a);
        chk(a[5] == 1, "R9 q5 high", a[5], 1);
        op_timeout = 0;

        phase = "R11";
        @(negedge clk); rd_strobe = 1; @(negedge clk); a = dq_out;
        idle(3);
        chk(dq_out[6] == a[6], "R11 held strobe", dq_out[6], a[6]);
        rd_strobe = 0; op_program = 0; idle(1);
        rd(0, a);
        chk(a == 8'h3C, "R2 done returns array", a, 8'h3C);

        phase = "R6"; erase_sel = 8'b0010_0110; prot_mask = 8'b0000_0100; op_erase = 1;
        rd(1, a); rd(1, b);
        chk(a[2] != b[2], "R6 q2 flip selected", b[2], !a[2]);
        rd(2, c);
        chk(c[2] == b[2], "R8 protected no q2", c[2], b[2]);
        rd(7, a);
        chk(a[2] == c[2] && a[6] != c[6], "R6 unselected q2 hold q6 flip", a, c ^ 8'h40);

        phase = "R4"; op_suspend = 1;
        rd(5, a); rd(5, b);
        chk(a[6] == b[6], "R4 q6 steady", b[6], a[6]);
        chk(a[2] != b[2], "R6 q2 in suspend", b[2], !a[2]);
        rd(7, c);
        chk(c == 8'h3C, "R4 unselected array", c, 8'h3C);

        phase = "R5"; op_susp_prog = 1;
        rd(7, a); rd(0, b);
        chk(a[6] != b[6], "R5 q6 flip", b[6], !a[6]);
        op_susp_prog = 0;
        rd(1, a); rd(1, b);
        chk(a[6] == b[6], "R5 q6 stops", b[6], a[6]);
        op_suspend = 0; op_erase = 0; erase_sel = 0;

        phase = "R7";
        @(negedge clk); prog_sector = 2; go_prog = 1; @(negedge clk); go_prog = 0;
        rd(4, a); rd(4, b);
        chk(a[6] != b[6], "R7 window toggles", b[6], !a[6]);
        idle(WIN);
        rd(4, c);
        chk(c == 8'h3C, "R7 after window array", c, 8'h3C);

        phase = "R8";
        @(negedge clk); erase_sel = 8'b0000_0100; go_erase = 1; @(negedge clk); go_erase = 0;
        rd(2, a); rd(2, b);
        chk(a[6] != b[6] && a[2] == b[2], "R8 all protected window", b, a ^ 8'h40);
        idle(WIN);
        rd(2, c);
        chk(c == 8'h3C, "R8 after window array", c, 8'h3C);
        @(negedge clk); erase_sel = 8'b0000_0110; go_erase = 1; @(negedge clk); go_erase = 0;
        rd(0, a);
        chk(a == 8'h3C, "R8 partial no window", a, 8'h3C);

        idle(2);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule